// File: doc/BRIEF.md
# Interleaved MSI Vector Interrupt Controller

This block collects message-signalled interrupts for a host bridge. An inbound MSI write lands on a doorbell address carrying a vector number. The block records that vector as a pending bit in one of eight small status banks. The vectors are interleaved across the banks: consecutive vectors go to consecutive banks, and each bank holds every eighth vector. Each bank has its own enable mask. The pending bits that are also enabled are ORed together to drive one interrupt line per bank toward the host interrupt controller.

Software uses a single 32-bit register port. Through it, software reads the pending bits, acknowledges them by writing ones, and sets or clears enable bits without a read-modify-write. It also writes a line index to an end-of-interrupt address. An end-of-interrupt drops the matching line for one cycle. If the line still has enabled, pending work, it rises again, so a level-sensitive controller sees a fresh edge.

Top module: `msi_ilv_ctrl`

## Requirements
- R1: After reset, every pending bit, every enable bit, every interrupt line and the read data are zero.
- R2: A write of value v to the doorbell at byte address 0x054 sets the pending bit for vector n = v & 31, whether or not that vector is enabled. Vector n lives in bank n % 8 at bit n / 8, so bank 0 holds vectors 0, 8, 16 and 24.
- R3: A read of address 0x104 + 16*r returns the pending bits of bank r in rdata[3:0] and zeros above.
- R4: A write to 0x104 + 16*r clears each pending bit of bank r whose wdata bit is 1 and leaves the others unchanged.
- R5: A write to 0x108 + 16*r sets the enable bits of bank r that are 1 in wdata[3:0]. A write to 0x10C + 16*r clears them. A read of either address returns the current enable mask of bank r in rdata[3:0].
- R6: irq_line[r] is high one cycle after bank r has a bit that is both pending and enabled, and low one cycle after it has none.
- R7: A write of k = r + 4 (r from 0 to 7) to the end-of-interrupt address 0x050 holds irq_line[r] low in the cycle that follows. In the cycle after that, the line returns high if bank r still has enabled pending bits. Values k of 0 to 3 and 12 or above change no line.
- R8: Read data appears in the cycle after rd_en. Reads of any other address, the doorbell included, return zero. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_line | output | 8 | One interrupt line per status bank |

## Verification
Every write takes effect at the clock edge that samples it. A pending or enable change appears on irq_line one edge later. Read data appears one edge after rd_en. An end-of-interrupt pulls its line low at the sampling edge, and the line can rise again at the next edge. The bench drives inputs and samples outputs on falling edges. It checks irq_line only after the register edge and the line-register edge have both passed. It checks the end-of-interrupt gap in the first falling edge after the write, and the re-assertion in the second.

// File: rtl/msi_ilv_pkg.sv
package msi_ilv_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // Fixed register locations; software decodes these, so they are kept.
  localparam logic [ADDR_W-1:0] EOI_ADDR      = 12'h050;
  localparam logic [ADDR_W-1:0] DOORBELL_ADDR = 12'h054;
  localparam logic [ADDR_W-1:0] BANK_BASE     = 12'h100;

  // Offsets of the three per-bank registers inside a 16-byte slot.
  localparam logic [3:0] STAT_OFS  = 4'h4;
  localparam logic [3:0] ENSET_OFS = 4'h8;
  localparam logic [3:0] ENCLR_OFS = 4'hC;

  // First end-of-interrupt code that names an MSI bank; lower codes are legacy.
  localparam int EOI_MSI_FIRST = 4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STAT,
    ACC_ENSET,
    ACC_ENCLR
  } bank_acc_e;

endpackage

// File: rtl/msi_ilv_decode.sv
module msi_ilv_decode
  import msi_ilv_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int BITS_PER_REG = 4
) (
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output bank_acc_e                   acc,
  output logic                        bank_hit,
  output logic [$clog2(NUM_REGS)-1:0] bank_idx,
  output logic                        db_hit,
  output logic [$clog2(NUM_REGS)-1:0] db_reg,
  output logic [$clog2(NUM_REGS*BITS_PER_REG)-$clog2(NUM_REGS)-1:0] db_bit,
  output logic [NUM_REGS-1:0]         eoi_vec
);

  localparam int VEC_W  = $clog2(NUM_REGS * BITS_PER_REG);
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(NUM_REGS);

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;
  logic [VEC_W-1:0]  vec;
  logic [DATA_W-1:0] k_rel;

  // Bank register decode
  always_comb begin
    off      = addr - BANK_BASE;
    slot     = off[ADDR_W-1:4];
    bank_hit = (addr >= BANK_BASE) && (slot < SLOT_LIM);
    bank_idx = slot[REG_W-1:0];
    case (off[3:0])
      STAT_OFS:  acc = ACC_STAT;
      ENSET_OFS: acc = ACC_ENSET;
      ENCLR_OFS: acc = ACC_ENCLR;
      default:   acc = ACC_NONE;
    endcase
    if (!bank_hit) acc = ACC_NONE;
  end

  // Doorbell: interleave vector into (bank, bit)
  always_comb begin
    db_hit = wr_en && (addr == DOORBELL_ADDR);
    vec    = wdata[VEC_W-1:0];
    db_reg = vec[REG_W-1:0];
    db_bit = vec[VEC_W-1:REG_W];
  end

  // End-of-interrupt: code k selects bank k - EOI_MSI_FIRST
  always_comb begin
    k_rel   = wdata - DATA_W'(EOI_MSI_FIRST);
    eoi_vec = '0;
    if (wr_en && (addr == EOI_ADDR) && (k_rel < DATA_W'(NUM_REGS)))
      eoi_vec[k_rel[REG_W-1:0]] = 1'b1;
  end

endmodule

// File: rtl/msi_ilv_bank.sv
module msi_ilv_bank #(
  parameter int BITS_PER_REG = 4,
  parameter int BIT_W        = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stat_wr,
  input  logic                    en_set,
  input  logic                    en_clr,
  input  logic [BITS_PER_REG-1:0] wbits,
  input  logic                    db_hit,
  input  logic [BIT_W-1:0]        db_bit,
  input  logic                    eoi_hit,
  output logic [BITS_PER_REG-1:0] stat_q,
  output logic [BITS_PER_REG-1:0] en_q,
  output logic                    irq_q
);

  logic [BITS_PER_REG-1:0] db_mask;
  logic [BITS_PER_REG-1:0] clr_mask;
  logic [BITS_PER_REG-1:0] stat_d;
  logic [BITS_PER_REG-1:0] en_d;
  logic                    stat_we;
  logic                    en_we;
  logic                    irq_d;

  // Next state
  always_comb begin
    db_mask  = db_hit  ? (BITS_PER_REG'(1) << db_bit) : '0;
    clr_mask = stat_wr ? wbits : '0;
    stat_we  = db_hit | stat_wr;
    stat_d   = (stat_q & ~clr_mask) | db_mask;

    en_we = en_set | en_clr;
    if (en_set)      en_d = en_q | wbits;
    else if (en_clr) en_d = en_q & ~wbits;
    else             en_d = en_q;

    irq_d = eoi_hit ? 1'b0 : |(stat_q & en_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_we) stat_q <= stat_d;
      if (en_we)   en_q   <= en_d;
      irq_q <= irq_d;
    end
  end

  // R2
  doorbell_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit |=> ((stat_q & $past(db_mask)) == $past(db_mask)));

  // R2
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !db_hit |=> ((stat_q & ~$past(stat_q)) == '0));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !db_hit) |=> ((stat_q & $past(wbits)) == '0));

  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> ((en_q & $past(wbits)) == '0));

  // R6
  irq_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(stat_q & en_q)));

  // R7
  eoi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> !irq_q);

endmodule

// File: rtl/msi_ilv_rdmux.sv
module msi_ilv_rdmux
  import msi_ilv_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int BITS_PER_REG = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   rd_en,
  input  bank_acc_e                              acc,
  input  logic [$clog2(NUM_REGS)-1:0]            bank_idx,
  input  logic [NUM_REGS-1:0][BITS_PER_REG-1:0]  stat_all,
  input  logic [NUM_REGS-1:0][BITS_PER_REG-1:0]  en_all,
  output logic [DATA_W-1:0]                      rdata
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    case (acc)
      ACC_STAT:              rdata_d = DATA_W'(stat_all[bank_idx]);
      ACC_ENSET, ACC_ENCLR:  rdata_d = DATA_W'(en_all[bank_idx]);
      default:               rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (acc == ACC_NONE)) |=> (rdata == '0));

endmodule

// File: rtl/msi_ilv_ctrl.sv
module msi_ilv_ctrl
  import msi_ilv_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int BITS_PER_REG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_REGS-1:0] irq_line
);

  localparam int VEC_W = $clog2(NUM_REGS * BITS_PER_REG);
  localparam int REG_W = $clog2(NUM_REGS);
  localparam int BIT_W = VEC_W - REG_W;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bank_acc_e                            acc;
  logic                                 bank_hit;
  logic [REG_W-1:0]                     bank_idx;
  logic                                 db_hit;
  logic [REG_W-1:0]                     db_reg;
  logic [BIT_W-1:0]                     db_bit;
  logic [NUM_REGS-1:0]                  eoi_vec;
  logic [NUM_REGS-1:0][BITS_PER_REG-1:0] stat_all;
  logic [NUM_REGS-1:0][BITS_PER_REG-1:0] en_all;

  msi_ilv_decode #(
    .NUM_REGS    (NUM_REGS),
    .BITS_PER_REG(BITS_PER_REG)
  ) u_decode (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .acc     (acc),
    .bank_hit(bank_hit),
    .bank_idx(bank_idx),
    .db_hit  (db_hit),
    .db_reg  (db_reg),
    .db_bit  (db_bit),
    .eoi_vec (eoi_vec)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
    logic sel;
    assign sel = wr_en && bank_hit && (bank_idx == REG_W'(r));

    msi_ilv_bank #(
      .BITS_PER_REG(BITS_PER_REG),
      .BIT_W       (BIT_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .stat_wr(sel && (acc == ACC_STAT)),
      .en_set (sel && (acc == ACC_ENSET)),
      .en_clr (sel && (acc == ACC_ENCLR)),
      .wbits  (wdata[BITS_PER_REG-1:0]),
      .db_hit (db_hit && (db_reg == REG_W'(r))),
      .db_bit (db_bit),
      .eoi_hit(eoi_vec[r]),
      .stat_q (stat_all[r]),
      .en_q   (en_all[r]),
      .irq_q  (irq_line[r])
    );
  end

  msi_ilv_rdmux #(
    .NUM_REGS    (NUM_REGS),
    .BITS_PER_REG(BITS_PER_REG)
  ) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_en   (rd_en),
    .acc     (acc),
    .bank_idx(bank_idx),
    .stat_all(stat_all),
    .en_all  (en_all),
    .rdata   (rdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |=> (irq_line == '0));

endmodule

// File: tb/tb_msi_ilv_ctrl.sv
`timescale 1ns/1ps
module tb_msi_ilv_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  msi_ilv_ctrl dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_line(irq_line)
  );

  // {doorbell value, expected bank, expected bit}
  localparam logic [39:0] VEC_TBL [0:7] = '{
    {32'd0,          4'd0, 4'd0},
    {32'd8,          4'd0, 4'd1},
    {32'd17,         4'd1, 4'd2},
    {32'd25,         4'd1, 4'd3},
    {32'd31,         4'd7, 4'd3},
    {32'd6,          4'd6, 4'd0},
    {32'd33,         4'd1, 4'd0},
    {32'hFFFF_FFE4,  4'd4, 4'd0}
  };

  function automatic logic [11:0] stat_a(int r);  return 12'h104 + 12'(16 * r); endfunction
  function automatic logic [11:0] enset_a(int r); return 12'h108 + 12'(16 * r); endfunction
  function automatic logic [11:0] enclr_a(int r); return 12'h10C + 12'(16 * r); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  irq_before;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    check("R1 irq in reset", 32'(irq_line), 32'h0);
    check("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(stat_a(3), rd);   check("R1 status zero", rd, 32'h0);
    bus_read(enset_a(6), rd);  check("R1 enable zero", rd, 32'h0);

    // R5: enable every bank
    for (int r = 0; r < 8; r++) bus_write(enset_a(r), 32'hF);
    bus_read(enclr_a(3), rd);  check("R5 enable readback via clear addr", rd, 32'hF);

    // R2 R3 R4 R6: table walk
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      int er, eb;
      v  = VEC_TBL[i][39:8];
      er = int'(VEC_TBL[i][7:4]);
      eb = int'(VEC_TBL[i][3:0]);
      bus_write(12'h054, v);
      bus_read(stat_a(er), rd);
      check("R2 R3 pending bit", rd, 32'(1) << eb);
      check("R6 line asserted", 32'(irq_line), 32'(1) << er);
      bus_write(stat_a(er), 32'hF);
      @(negedge clk);
      check("R6 line drops after clear", 32'(irq_line), 32'h0);
      bus_read(stat_a(er), rd);
      check("R4 status cleared", rd, 32'h0);
    end

    // R4: partial clear, vectors 2 and 10 both live in bank 2
    bus_write(12'h054, 32'd2);
    bus_write(12'h054, 32'd10);
    bus_write(stat_a(2), 32'h1);
    bus_read(stat_a(2), rd);
    check("R4 partial clear keeps other bit", rd, 32'h2);

    // R6: disabled vector stays silent, enabling raises line
    bus_write(enclr_a(5), 32'hF);
    bus_write(12'h054, 32'd5);
    bus_read(stat_a(5), rd);
    check("R2 pending while disabled", rd, 32'h1);
    check("R6 disabled bank silent", 32'(irq_line[5]), 32'h0);
    bus_write(enset_a(5), 32'h1);
    @(negedge clk);
    check("R6 line after enable", 32'(irq_line[5]), 32'h1);
    bus_read(enclr_a(5), rd);
    check("R5 enable mask after set", rd, 32'h1);

    // R7: end-of-interrupt for bank 5 (code 9)
    bus_write(12'h050, 32'd9);
    check("R7 line low after EOI", 32'(irq_line[5]), 32'h0);
    check("R7 other line kept", 32'(irq_line[2]), 32'h1);
    @(negedge clk);
    check("R7 line re-asserts", 32'(irq_line[5]), 32'h1);

    // R7: legacy and out-of-range codes
    irq_before = irq_line;
    bus_write(12'h050, 32'd2);
    check("R7 legacy code ignored", 32'(irq_line), 32'(irq_before));
    bus_write(12'h050, 32'd12);
    check("R7 code 12 ignored", 32'(irq_line), 32'(irq_before));
    @(negedge clk);
    check("R7 lines steady", 32'(irq_line), 32'(irq_before));

    // R8: unmapped accesses
    bus_read(12'h200, rd);  check("R8 unmapped read", rd, 32'h0);
    bus_read(12'h054, rd);  check("R8 doorbell reads zero", rd, 32'h0);
    bus_write(12'h184, 32'hF);
    bus_write(12'h10C + 12'h080, 32'hF);
    @(negedge clk);
    check("R8 stray write no irq change", 32'(irq_line), 32'(irq_before));
    bus_read(enset_a(0), rd);  check("R8 enables untouched", rd, 32'hF);
    bus_read(stat_a(2), rd);   check("R8 status untouched", rd, 32'h2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule